// File: doc/BRIEF.md
# Stream to AXI4 Memory-Mapped Expander

This block is the far-end half of a link that carries AXI4 memory-mapped traffic over a pair of AXI4-Stream interfaces. On its stream slave it receives tagged packets that each hold one write-address, read-address or write-data word. A word may have been cut into several narrow stream beats. The block collects the beats, rebuilds the word, and presents it on the matching channel of its AXI4 master port. The stream slave is held off while the rebuilt word waits for the downstream slave.

In the other direction it takes read-data and write-response transfers from the memory-mapped side. Each one is wrapped as a tagged packet and sent on a single stream master, with the two channels sharing it in time. Once a read burst has started, it keeps the return stream until its final beat has been accepted. A write response can only go out at a burst boundary, so heavy write-response traffic during reads lowers read bandwidth. The stream width in bytes is a parameter and must equal the width used by the partner encapsulator.

Top module: `mm_stream_expander`

## Requirements
- R1: The packet tag is bits [7:0] of the first beat. Tag 0 is issued on the write-address channel, tag 1 on the read-address channel and tag 2 on the write-data channel, and only that channel's valid rises.
- R2: Beat k of a packet carries packet bits [k*8*BYTES +: 8*BYTES]. The payload starts at bit 8. An address word holds, from the low end: address (ADDR_W), length (8), size (3), burst (2), id (ID_W). A write-data word holds: data (DATA_W), strobes (DATA_W/8), last (1). The word is issued only after the beat with TLAST has been taken.
- R3: While a rebuilt word waits on its channel, s_tready is low and the word is held stable. s_tready returns high in the cycle after the handshake, and no word is lost.
- R4: A packet with a tag above 2 is consumed up to TLAST and raises no AXI valid. It sets err, which stays set until reset.
- R5: A read-data transfer is returned as a packet with tag 3 in bits [7:0], followed by data, id, resp (2) and last (1) from bit 8 upward. The rest of the packet is zero, and TLAST is set only on its final beat.
- R6: A write response is returned as a packet with tag 4, followed by id and resp (2) from bit 8 upward. It is zero-padded, and TLAST is set on its final beat.
- R7: After a read-data transfer with rlast=0 has been taken, bready stays low until a read-data transfer with rlast=1 has been taken.
- R8: Outside a read burst, when both are pending, the write response is taken before the read data.
- R9: While m_tvalid is high and m_tready is low, m_tvalid stays high and m_tdata and m_tlast stay unchanged.
- R10: After reset, no AXI valid and no stream valid is asserted, err is 0 and s_tready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 8*BYTES | Incoming packet beat |
| s_tvalid | input | 1 | Incoming beat valid |
| s_tlast | input | 1 | Final beat of an incoming packet |
| s_tready | output | 1 | Incoming beat accepted |
| m_tdata | output | 8*BYTES | Return packet beat |
| m_tvalid | output | 1 | Return beat valid |
| m_tlast | output | 1 | Final beat of a return packet |
| m_tready | input | 1 | Return beat accepted |
| awaddr | output | ADDR_W | Write address |
| awlen | output | 8 | Write burst length |
| awsize | output | 3 | Write beat size |
| awburst | output | 2 | Write burst type |
| awid | output | ID_W | Write id |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| araddr | output | ADDR_W | Read address |
| arlen | output | 8 | Read burst length |
| arsize | output | 3 | Read beat size |
| arburst | output | 2 | Read burst type |
| arid | output | ID_W | Read id |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write strobes |
| wlast | output | 1 | Last write beat |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bid | input | ID_W | Response id |
| bresp | input | 2 | Write response |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| rid | input | ID_W | Read id |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response |
| rlast | input | 1 | Last read beat |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| err | output | 1 | Sticky flag for a packet with an unknown tag |

## Verification
The bench uses the defaults: BYTES=4, ADDR_W=32, DATA_W=32 and ID_W=4. With these values every address, write-data and read-data packet spans two beats while a write response fits in one. This exercises reassembly across beats on the way in and return packets of mixed length on the way out. The 32-bit beat also places field boundaries inside a beat and across the beat seam, so a misplaced field or a wrong beat offset shows up as a wrong value.

// File: rtl/mm_stream_expander.sv
module mm_stream_expander #(
  parameter int BYTES  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [8*BYTES-1:0]  s_tdata,
  input  logic                s_tvalid,
  input  logic                s_tlast,
  output logic                s_tready,
  output logic [8*BYTES-1:0]  m_tdata,
  output logic                m_tvalid,
  output logic                m_tlast,
  input  logic                m_tready,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic [ID_W-1:0]     awid,
  output logic                awvalid,
  input  logic                awready,
  output logic [ADDR_W-1:0]   araddr,
  output logic [7:0]          arlen,
  output logic [2:0]          arsize,
  output logic [1:0]          arburst,
  output logic [ID_W-1:0]     arid,
  output logic                arvalid,
  input  logic                arready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [ID_W-1:0]     bid,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready,
  input  logic [ID_W-1:0]     rid,
  input  logic [DATA_W-1:0]   rdata,
  input  logic [1:0]          rresp,
  input  logic                rlast,
  input  logic                rvalid,
  output logic                rready,
  output logic                err
);
  localparam int BW        = 8 * BYTES;
  localparam int STRB_W    = DATA_W / 8;
  localparam int AX_BITS   = ADDR_W + 13 + ID_W;
  localparam int WD_BITS   = DATA_W + STRB_W + 1;
  localparam int IN_BITS   = 8 + ((AX_BITS > WD_BITS) ? AX_BITS : WD_BITS);
  localparam int IN_BEATS  = (IN_BITS + BW - 1) / BW;
  localparam int R_BEATS   = (8 + DATA_W + ID_W + 3 + BW - 1) / BW;
  localparam int B_BEATS   = (8 + ID_W + 2 + BW - 1) / BW;
  localparam int OUT_BEATS = (R_BEATS > B_BEATS) ? R_BEATS : B_BEATS;
  localparam int MAXB      = (IN_BEATS > OUT_BEATS) ? IN_BEATS : OUT_BEATS;
  localparam int CW        = $clog2(MAXB + 1);
  localparam int IBW       = IN_BEATS * BW;
  localparam int OBW       = OUT_BEATS * BW;

  // inbound reassembly
  logic [IBW-1:0] ibuf;
  logic [CW-1:0]  icnt;
  logic           issue;

  wire [7:0] cur_tag = (icnt == '0) ? s_tdata[7:0] : ibuf[7:0];
  wire       in_hs   = s_tvalid && s_tready;
  wire       fire    = (awvalid && awready) || (arvalid && arready) || (wvalid && wready);

  assign s_tready = !issue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibuf  <= '0;
      icnt  <= '0;
      issue <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (in_hs) begin
        if (icnt < CW'(IN_BEATS)) begin
          ibuf[icnt*BW +: BW] <= s_tdata;
          icnt <= icnt + 1'b1;
        end
        if (s_tlast) begin
          icnt <= '0;
          if (cur_tag <= 8'd2) issue <= 1'b1;
          else begin
            err  <= 1'b1;
            ibuf <= '0;
          end
        end
      end
      if (issue && fire) begin
        issue <= 1'b0;
        ibuf  <= '0;
      end
    end
  end

  assign awvalid = issue && (ibuf[7:0] == 8'd0);
  assign arvalid = issue && (ibuf[7:0] == 8'd1);
  assign wvalid  = issue && (ibuf[7:0] == 8'd2);

  assign awaddr  = ibuf[8 +: ADDR_W];
  assign awlen   = ibuf[8 + ADDR_W +: 8];
  assign awsize  = ibuf[16 + ADDR_W +: 3];
  assign awburst = ibuf[19 + ADDR_W +: 2];
  assign awid    = ibuf[21 + ADDR_W +: ID_W];
  assign araddr  = awaddr;
  assign arlen   = awlen;
  assign arsize  = awsize;
  assign arburst = awburst;
  assign arid    = awid;
  assign wdata   = ibuf[8 +: DATA_W];
  assign wstrb   = ibuf[8 + DATA_W +: STRB_W];
  assign wlast   = ibuf[8 + DATA_W + STRB_W];

  // return packing and arbitration
  logic [OBW-1:0] obuf;
  logic           osend;
  logic [CW-1:0]  obeat;
  logic [CW-1:0]  olast;
  logic           r_burst;

  assign bready = !osend && !r_burst && bvalid;
  assign rready = !osend && (r_burst || !bvalid);

  wire            r_hs  = rvalid && rready;
  wire            b_hs  = bvalid && bready;
  wire [OBW-1:0]  r_pkt = OBW'({rlast, rresp, rid, rdata, 8'd3});
  wire [OBW-1:0]  b_pkt = OBW'({bresp, bid, 8'd4});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obuf    <= '0;
      osend   <= 1'b0;
      obeat   <= '0;
      olast   <= '0;
      r_burst <= 1'b0;
    end else begin
      if (r_hs) begin
        obuf    <= r_pkt;
        osend   <= 1'b1;
        obeat   <= '0;
        olast   <= CW'(R_BEATS - 1);
        r_burst <= !rlast;
      end else if (b_hs) begin
        obuf  <= b_pkt;
        osend <= 1'b1;
        obeat <= '0;
        olast <= CW'(B_BEATS - 1);
      end
      if (osend && m_tready) begin
        if (obeat == olast) osend <= 1'b0;
        else obeat <= obeat + 1'b1;
      end
    end
  end

  assign m_tvalid = osend;
  assign m_tdata  = obuf[obeat*BW +: BW];
  assign m_tlast  = osend && (obeat == olast);

  p_one_channel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({awvalid, arvalid, wvalid}));
  p_hold_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid || arvalid || wvalid) |-> !s_tready);
  p_aw_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awid)));
  p_w_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wdata)));
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_burst_blocks_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rready && !rlast) |=> !bready);
  p_b_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rready && bready));
  p_out_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
endmodule

// File: tb/mm_stream_expander_tb.sv
`timescale 1ns/1ps
module mm_stream_expander_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [31:0] s_tdata = '0;
  logic s_tvalid = 0, s_tlast = 0, s_tready;
  logic [31:0] m_tdata;
  logic m_tvalid, m_tlast, m_tready = 0;
  logic [31:0] awaddr, araddr, wdata;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize;
  logic [1:0] awburst, arburst;
  logic [3:0] awid, arid, wstrb;
  logic awvalid, arvalid, wvalid, wlast, bready, rready, err;
  logic awready = 0, arready = 0, wready = 0;
  logic [3:0] bid = '0, rid = '0;
  logic [1:0] bresp = '0, rresp = '0;
  logic bvalid = 0, rvalid = 0, rlast = 0;
  logic [31:0] rdata = '0;

  mm_stream_expander u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst), .awid(awid),
    .awvalid(awvalid), .awready(awready),
    .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst), .arid(arid),
    .arvalid(arvalid), .arready(arready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready),
    .err(err)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input logic [127:0] p, input int nb);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      s_tdata = p[k*32 +: 32];
      s_tvalid = 1;
      s_tlast = (k == nb - 1);
      while (!s_tready) @(negedge clk);
    end
    @(negedge clk);
    s_tvalid = 0;
    s_tlast = 0;
  endtask

  task automatic get_pkt(output logic [127:0] p, output int nb);
    bit last = 0;
    p = '0;
    nb = 0;
    @(negedge clk);
    m_tready = 1;
    while (!last) begin
      if (m_tvalid) begin
        p[nb*32 +: 32] = m_tdata;
        last = m_tlast;
        nb++;
      end
      @(negedge clk);
    end
    m_tready = 0;
  endtask

  task automatic drive_r(input logic [31:0] d, input logic [3:0] id, input logic [1:0] rs, input logic l);
    @(negedge clk);
    rdata = d; rid = id; rresp = rs; rlast = l; rvalid = 1;
    #1;
    while (!rready) begin @(negedge clk); #1; end
    @(negedge clk);
    rvalid = 0;
  endtask

  task automatic drive_b(input logic [3:0] id, input logic [1:0] rs);
    @(negedge clk);
    bid = id; bresp = rs; bvalid = 1;
    #1;
    while (!bready) begin @(negedge clk); #1; end
    @(negedge clk);
    bvalid = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!awvalid && !arvalid && !wvalid, "R10 axi valids", {awvalid, arvalid, wvalid}, 0);
    chk(!m_tvalid, "R10 m_tvalid", m_tvalid, 0);
    chk(!err, "R10 err", err, 0);
    chk(s_tready, "R10 s_tready", s_tready, 1);
  endtask

  task automatic t_aw;
    logic [127:0] p = '0;
    p[56:0] = {4'h5, 2'd1, 3'd2, 8'd7, 32'h1234_5678, 8'h00};
    fork
      send_pkt(p, 2);
      begin
        while (!awvalid) @(negedge clk);
        chk(awaddr == 32'h1234_5678 && awlen == 8'd7 && awsize == 3'd2 && awburst == 2'd1 && awid == 4'h5,
            "R2 aw fields", {awid, awburst, awsize, awlen, awaddr}, {4'h5, 2'd1, 3'd2, 8'd7, 32'h1234_5678});
        chk(!arvalid && !wvalid, "R1 only aw", {arvalid, wvalid}, 0);
        chk(!s_tready, "R3 held off", s_tready, 0);
        repeat (3) @(negedge clk);
        chk(awvalid && awaddr == 32'h1234_5678, "R3 aw held", awaddr, 32'h1234_5678);
        awready = 1;
        @(negedge clk);
        awready = 0;
        chk(!awvalid && s_tready, "R3 released", {awvalid, s_tready}, 2'b01);
      end
    join
  endtask

  task automatic t_ar;
    logic [127:0] p = '0;
    p[56:0] = {4'hA, 2'd2, 3'd3, 8'd255, 32'hCAFE_0040, 8'h01};
    fork
      send_pkt(p, 2);
      begin
        while (!arvalid) @(negedge clk);
        chk(araddr == 32'hCAFE_0040 && arlen == 8'd255 && arsize == 3'd3 && arburst == 2'd2 && arid == 4'hA,
            "R2 ar fields", {arid, arburst, arsize, arlen, araddr}, {4'hA, 2'd2, 3'd3, 8'd255, 32'hCAFE_0040});
        chk(!awvalid && !wvalid, "R1 only ar", {awvalid, wvalid}, 0);
        arready = 1;
        @(negedge clk);
        arready = 0;
        chk(!arvalid, "R3 ar done", arvalid, 0);
      end
    join
  endtask

  task automatic t_w;
    logic [127:0] p = '0;
    p[44:0] = {1'b1, 4'hA, 32'hDEAD_BEEF, 8'h02};
    fork
      send_pkt(p, 2);
      begin
        while (!wvalid) @(negedge clk);
        chk(wdata == 32'hDEAD_BEEF && wstrb == 4'hA && wlast, "R2 w fields",
            {wlast, wstrb, wdata}, {1'b1, 4'hA, 32'hDEAD_BEEF});
        chk(!awvalid && !arvalid, "R1 only w", {awvalid, arvalid}, 0);
        wready = 1;
        @(negedge clk);
        wready = 0;
        chk(!wvalid && s_tready, "R3 w done", {wvalid, s_tready}, 2'b01);
      end
    join
  endtask

  task automatic t_bad_tag;
    logic [127:0] p = '0;
    p[63:0] = 64'h1111_2222_3333_4407;
    send_pkt(p, 2);
    @(negedge clk);
    chk(err, "R4 err set", err, 1);
    chk(!awvalid && !arvalid && !wvalid, "R4 no valid", {awvalid, arvalid, wvalid}, 0);
    chk(s_tready, "R4 still ready", s_tready, 1);
    repeat (3) @(negedge clk);
    chk(err, "R4 err sticky", err, 1);
  endtask

  task automatic t_r_return;
    logic [127:0] p, e;
    int nb;
    e = '0;
    e[46:0] = {1'b1, 2'd2, 4'h9, 32'h0BAD_F00D, 8'h03};
    fork
      drive_r(32'h0BAD_F00D, 4'h9, 2'd2, 1'b1);
      get_pkt(p, nb);
    join
    chk(p == e, "R5 r packet", p, e);
    chk(nb == 2, "R5 r tlast beat", nb, 2);
  endtask

  task automatic t_b_return;
    logic [127:0] p, e;
    int nb;
    e = '0;
    e[13:0] = {2'd1, 4'h3, 8'h04};
    fork
      drive_b(4'h3, 2'd1);
      get_pkt(p, nb);
    join
    chk(p == e, "R6 b packet", p, e);
    chk(nb == 1, "R6 b tlast beat", nb, 1);
  endtask

  task automatic t_burst_priority;
    logic [127:0] p1, p2, e1, e2;
    int n1, n2;
    fork
      drive_r(32'h1, 4'h2, 2'd0, 1'b0);
      get_pkt(p1, n1);
    join
    e1 = '0; e1[46:0] = {1'b1, 2'd0, 4'h2, 32'h2, 8'h03};
    e2 = '0; e2[13:0] = {2'd0, 4'h6, 8'h04};
    fork
      drive_b(4'h6, 2'd0);
      begin
        @(negedge clk);
        repeat (3) begin
          @(negedge clk); #1;
          chk(!bready, "R7 b blocked in burst", bready, 0);
        end
        drive_r(32'h2, 4'h2, 2'd0, 1'b1);
      end
      begin
        get_pkt(p1, n1);
        get_pkt(p2, n2);
      end
    join
    chk(p1 == e1, "R7 burst end first", p1, e1);
    chk(p2 == e2, "R7 b after burst", p2, e2);
  endtask

  task automatic t_b_first;
    logic [127:0] p1, p2, e1, e2;
    int n1, n2;
    e1 = '0; e1[13:0] = {2'd3, 4'hC, 8'h04};
    e2 = '0; e2[46:0] = {1'b1, 2'd0, 4'h1, 32'h5555_AAAA, 8'h03};
    fork
      drive_r(32'h5555_AAAA, 4'h1, 2'd0, 1'b1);
      drive_b(4'hC, 2'd3);
      begin
        get_pkt(p1, n1);
        get_pkt(p2, n2);
      end
    join
    chk(p1 == e1, "R8 b first", p1, e1);
    chk(p2 == e2, "R8 r second", p2, e2);
  endtask

  task automatic t_out_stall;
    logic [127:0] p, e;
    logic [31:0] d0;
    int nb;
    e = '0;
    e[46:0] = {1'b0, 2'd1, 4'h7, 32'h8765_4321, 8'h03};
    m_tready = 0;
    fork
      drive_r(32'h8765_4321, 4'h7, 2'd1, 1'b0);
      begin
        while (!m_tvalid) @(negedge clk);
        d0 = m_tdata;
        repeat (3) begin
          @(negedge clk);
          chk(m_tvalid && m_tdata == d0 && !m_tlast, "R9 held under stall", m_tdata, d0);
        end
        get_pkt(p, nb);
      end
    join
    chk(p == e, "R9 packet intact", p, e);
    fork
      drive_r(32'h0, 4'h7, 2'd0, 1'b1);
      get_pkt(p, nb);
    join
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_aw();
    t_ar();
    t_w();
    t_bad_tag();
    t_ar();
    t_r_return();
    t_b_return();
    t_burst_priority();
    t_b_first();
    t_out_stall();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule